// File: doc/BRIEF.md
# Substitution-Permutation Diffusion Extractor for a Connectivity PUF

This block turns a per-chip grid of open and closed interconnects into a challenge-response function. A challenge vector of ROWS bits enters the first column of a grid of COLS columns. Each column mixes the vector with one column of connectivity bits through a NAND with a neighbouring row followed by an XOR. The last column's vector is the response. A plain XOR-NAND grid only moves a challenge bit one row per column. This block therefore inserts, after every SP-th column, a layer of 4-bit substitution boxes and a bit permutation across the whole vector. A single flipped challenge bit then reaches every row of the response.

A build-time parameter selects which diffusion layers exist: none, substitution only, permutation only, or both. The datapath is one combinational network. When REG_OUT is set, an input strobe captures the result into an output register, and a valid flag follows one cycle later. When REG_OUT is clear, the response and the valid flag pass straight through. The connectivity input is normally tied to the fabricated random structure. The challenge comes from whatever protocol logic uses the block.

Top module: `spn_puf_extractor`

## Requirements
- R1: Columns are numbered j = 1..COLS and rows i = 0..ROWS-1. Column j reads its connectivity bits from connMatrix[(j-1)*ROWS + i]. It computes next[i] = NOT(conn & nb) XOR prev[i]. For odd j, nb is prev[i-1]; for even j, nb is prev[i+1]. A neighbour outside the grid reads 0. Column 1 takes the challenge as prev. With all connectivity bits 0, every column inverts its vector, so in the XOR-only mode an even COLS returns the challenge unchanged.
- R2: When j mod SP = 0 and the mode enables both layers, column j applies its XOR-NAND step, then the substitution layer, then the permutation layer. Other columns apply only the XOR-NAND step.
- R3: The substitution layer replaces each nibble bits [4n+3:4n] with S(x). S maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.
- R4: The permutation layer moves bit i to position (i*ROWS/4) mod (ROWS-1) for i < ROWS-1. Bit ROWS-1 stays in place.
- R5: MODE encoding: bit 0 enables substitution and bit 1 enables permutation. Value 0 is XOR only, 1 is XOR with substitution, 2 is XOR with permutation, and 3 is all three. Every mode uses the same sampling schedule.
- R6: With REG_OUT=1, a cycle with inValid high captures the network output into response, and outValid is high in the next cycle. A cycle with inValid low leaves response unchanged and drives outValid low in the next cycle.
- R7: While rst_n is low, the registered response reads 0 and outValid reads 0.
- R8: In the default configuration with both layers enabled, flipping one challenge bit changes between 35% and 65% of the response bits, averaged over many random challenges and grids.
- R9: A ROWS value that is not a multiple of 4, or an SP below 1, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture register |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe: capture the current network result |
| challenge | input | ROWS | Challenge vector |
| connMatrix | input | ROWS*COLS | Connectivity grid, column-major, 1 = connected |
| outValid | output | 1 | Response is valid |
| response | output | ROWS | Extracted response |

## Verification
The clocked checks assume that challenge and connMatrix are stable and known whenever inValid is high. They also assume that, in registered mode, nothing but the strobe governs the output register. The bench changes every input only at the falling clock edge and holds it through the capturing rising edge. It drives only fully defined patterns, including all-open and all-closed grids. The combinational checks take the connectivity column as it is. They assume only that an all-open column must invert its input and that the permutation keeps the count of ones.

// File: rtl/spn_pkg.sv
`timescale 1ns/1ps
package spn_pkg;

  // bit 0: substitution layer, bit 1: permutation layer
  typedef enum logic [1:0] {
    MODE_XOR  = 2'd0,
    MODE_SUB  = 2'd1,
    MODE_PERM = 2'd2,
    MODE_FULL = 2'd3
  } spnMode_e;

  typedef struct packed {
    logic capture;
  } spnStrobe_t;

  function automatic logic [3:0] sboxLookup(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC;
      4'h1: y = 4'h5;
      4'h2: y = 4'h6;
      4'h3: y = 4'hB;
      4'h4: y = 4'h9;
      4'h5: y = 4'h0;
      4'h6: y = 4'hA;
      4'h7: y = 4'hD;
      4'h8: y = 4'h3;
      4'h9: y = 4'hE;
      4'hA: y = 4'hF;
      4'hB: y = 4'h8;
      4'hC: y = 4'h4;
      4'hD: y = 4'h7;
      4'hE: y = 4'h1;
      default: y = 4'h2;
    endcase
    return y;
  endfunction

  function automatic int permTarget(input int idx, input int rows);
    if (idx == rows - 1) return idx;
    return (idx * (rows / 4)) % (rows - 1);
  endfunction

endpackage

// File: rtl/spnColumn.sv
`timescale 1ns/1ps
module spnColumn
  import spn_pkg::*;
#(
  parameter int       ROWS    = 128,
  parameter int       COL_IDX = 1,
  parameter int       SP      = 2,
  parameter spnMode_e MODE    = MODE_FULL
) (
  input  logic [ROWS-1:0] prevVec,
  input  logic [ROWS-1:0] connCol,
  output logic [ROWS-1:0] nextVec
);

  localparam bit SAMPLED  = (COL_IDX % SP) == 0;
  localparam bit ODD_COL  = (COL_IDX % 2) == 1;
  localparam bit USE_SUB  = SAMPLED && (MODE == MODE_SUB  || MODE == MODE_FULL);
  localparam bit USE_PERM = SAMPLED && (MODE == MODE_PERM || MODE == MODE_FULL);
  localparam int NIBBLES  = ROWS / 4;

  logic [ROWS-1:0] nbVec;
  logic [ROWS-1:0] mixVec;
  logic [ROWS-1:0] subVec;
  logic [ROWS-1:0] permVec;

  // neighbour row: above for odd columns, below for even ones, 0 at the edge
  generate
    if (ODD_COL) begin : gNbAbove
      assign nbVec = {prevVec[ROWS-2:0], 1'b0};
    end else begin : gNbBelow
      assign nbVec = {1'b0, prevVec[ROWS-1:1]};
    end
  endgenerate

  assign mixVec = ~(connCol & nbVec) ^ prevVec;

  always_comb begin
    if (connCol == '0) begin
      assert_open_col_invert_R1: assert (mixVec == ~prevVec)
        else $error("open column did not invert its input");
    end
  end

  generate
    if (USE_SUB) begin : gSub
      for (genvar n = 0; n < NIBBLES; n++) begin : gNib
        assign subVec[4*n +: 4] = sboxLookup(mixVec[4*n +: 4]);
      end
    end else begin : gNoSub
      assign subVec = mixVec;
    end
  endgenerate

  generate
    if (USE_PERM) begin : gPerm
      for (genvar i = 0; i < ROWS; i++) begin : gBit
        localparam int DST = permTarget(i, ROWS);
        assign permVec[DST] = subVec[i];
      end
      always_comb begin
        assert_perm_weight_R4: assert ($countones(permVec) == $countones(subVec))
          else $error("permutation changed the number of ones");
      end
    end else begin : gNoPerm
      assign permVec = subVec;
    end
  endgenerate

  assign nextVec = permVec;

endmodule

// File: rtl/spnDatapath.sv
`timescale 1ns/1ps
module spnDatapath
  import spn_pkg::*;
#(
  parameter int       ROWS    = 128,
  parameter int       COLS    = 16,
  parameter int       SP      = 2,
  parameter spnMode_e MODE    = MODE_FULL,
  parameter bit       REG_OUT = 1'b1,
  localparam int      CONN_W  = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  spnStrobe_t       strb,
  input  logic [ROWS-1:0]  challenge,
  input  logic [CONN_W-1:0] conn,
  output logic [ROWS-1:0]  response
);

  logic [ROWS-1:0] stageVec [COLS+1];

  assign stageVec[0] = challenge;

  generate
    for (genvar j = 1; j <= COLS; j++) begin : gCol
      spnColumn #(
        .ROWS   (ROWS),
        .COL_IDX(j),
        .SP     (SP),
        .MODE   (MODE)
      ) uCol (
        .prevVec(stageVec[j-1]),
        .connCol(conn[(j-1)*ROWS +: ROWS]),
        .nextVec(stageVec[j])
      );
    end
  endgenerate

  generate
    if (REG_OUT) begin : gReg
      logic [ROWS-1:0] respQ;
      always_ff @(posedge clk) begin
        if (!rst_n)            respQ <= '0;
        else if (strb.capture) respQ <= stageVec[COLS];
      end
      assign response = respQ;

      assert_hold_no_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.capture |=> $stable(response))
        else $error("response moved without a capture strobe");
    end else begin : gComb
      assign response = stageVec[COLS];
    end
  endgenerate

endmodule

// File: rtl/spnControl.sv
`timescale 1ns/1ps
module spnControl
  import spn_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output spnStrobe_t strb,
  output logic       outValid
);

  assign strb.capture = inValid;

  generate
    if (REG_OUT) begin : gReg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rst_n) validQ <= 1'b0;
        else        validQ <= inValid;
      end
      assign outValid = validQ;

      assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> outValid)
        else $error("outValid missing one cycle after a request");

      assert_valid_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> !outValid)
        else $error("outValid high without a request");
    end else begin : gComb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/spn_puf_extractor.sv
`timescale 1ns/1ps
module spn_puf_extractor
  import spn_pkg::*;
#(
  parameter int       ROWS    = 128,
  parameter int       COLS    = 16,
  parameter int       SP      = 2,
  parameter spnMode_e MODE    = MODE_FULL,
  parameter bit       REG_OUT = 1'b1,
  localparam int      CONN_W  = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [ROWS-1:0]   challenge,
  input  logic [CONN_W-1:0] connMatrix,
  output logic              outValid,
  output logic [ROWS-1:0]   response
);

  // R9: parameter legality
  generate
    if ((ROWS % 4) != 0 || ROWS < 4) begin : gBadRows
      $error("ROWS must be a positive multiple of 4 (R9)");
    end
    if (SP < 1) begin : gBadSp
      $error("SP must be at least 1 (R9)");
    end
  endgenerate

  spnStrobe_t strb;

  spnControl #(
    .REG_OUT(REG_OUT)
  ) uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .strb    (strb),
    .outValid(outValid)
  );

  spnDatapath #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .SP     (SP),
    .MODE   (MODE),
    .REG_OUT(REG_OUT)
  ) uPath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .challenge(challenge),
    .conn     (connMatrix),
    .response (response)
  );

endmodule

// File: tb/spn_puf_extractor_tb.sv
`timescale 1ns/1ps
module spn_puf_extractor_tb;
  import spn_pkg::*;

  localparam int R  = 128;
  localparam int C  = 16;
  localparam int SP = 2;
  localparam int CW = R * C;

  localparam logic [3:0] SBOX_REF [16] = '{
    4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
    4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

  // {challenge seed, connectivity seed}; 0 = all zero, FFFFFFFF = all ones
  localparam logic [63:0] VEC_TABLE [10] = '{
    {32'h0000_0001, 32'h0000_0000},
    {32'hDEAD_BEEF, 32'h0000_0000},
    {32'h1234_5678, 32'hFFFF_FFFF},
    {32'h0000_0000, 32'hCAFE_F00D},
    {32'hFFFF_FFFF, 32'h0BAD_F00D},
    {32'h8BAD_F00D, 32'h1357_9BDF},
    {32'h2468_ACE0, 32'hFEED_FACE},
    {32'h0F0F_0F0F, 32'h7777_1111},
    {32'hA5A5_5A5A, 32'hFFFF_FFFF},
    {32'h3141_5926, 32'h2718_2818}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic          inValid = 1'b0;
  logic [R-1:0]  challenge = '0;
  logic [CW-1:0] conn = '0;
  logic [R-1:0]  resp0, resp1, resp2, resp3;
  logic          ov0, ov1, ov2, ov3;

  logic [3:0]    sbChal = '0;
  logic [3:0]    sbResp;
  logic          sbOv;
  logic [R-1:0]  pmChal = '0;
  logic [R-1:0]  pmResp;
  logic          pmOv;

  spn_puf_extractor #(.ROWS(R), .COLS(C), .SP(SP), .MODE(MODE_FULL), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .challenge(challenge),
    .connMatrix(conn), .outValid(ov3), .response(resp3));
  spn_puf_extractor #(.ROWS(R), .COLS(C), .SP(SP), .MODE(MODE_XOR), .REG_OUT(1'b1)) u_dutM0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .challenge(challenge),
    .connMatrix(conn), .outValid(ov0), .response(resp0));
  spn_puf_extractor #(.ROWS(R), .COLS(C), .SP(SP), .MODE(MODE_SUB), .REG_OUT(1'b1)) u_dutM1 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .challenge(challenge),
    .connMatrix(conn), .outValid(ov1), .response(resp1));
  spn_puf_extractor #(.ROWS(R), .COLS(C), .SP(SP), .MODE(MODE_PERM), .REG_OUT(1'b1)) u_dutM2 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .challenge(challenge),
    .connMatrix(conn), .outValid(ov2), .response(resp2));

  // one open column, substitution only: response = S(~challenge)
  spn_puf_extractor #(.ROWS(4), .COLS(1), .SP(1), .MODE(MODE_SUB), .REG_OUT(1'b0)) u_dutSbox (
    .clk(clk), .rst_n(rst_n), .inValid(1'b1), .challenge(sbChal),
    .connMatrix(4'b0000), .outValid(sbOv), .response(sbResp));
  // one open column, permutation only: response = P(~challenge)
  spn_puf_extractor #(.ROWS(R), .COLS(1), .SP(1), .MODE(MODE_PERM), .REG_OUT(1'b0)) u_dutPerm (
    .clk(clk), .rst_n(rst_n), .inValid(1'b1), .challenge(pmChal),
    .connMatrix({R{1'b0}}), .outValid(pmOv), .response(pmResp));

  function automatic logic [CW-1:0] expandBits(input logic [31:0] seed);
    logic [CW-1:0] v;
    logic [31:0] s;
    if (seed == 32'h0) return '0;
    if (seed == 32'hFFFF_FFFF) return '1;
    s = seed;
    for (int w = 0; w < CW / 32; w++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      v[w*32 +: 32] = s;
    end
    return v;
  endfunction

  function automatic logic [R-1:0] refModel(input logic [R-1:0] c,
                                            input logic [CW-1:0] v,
                                            input int mode);
    logic [R-1:0] cur, nxt, tmp;
    logic nb;
    cur = c;
    for (int j = 1; j <= C; j++) begin
      for (int i = 0; i < R; i++) begin
        if (j % 2 == 1) nb = (i == 0)     ? 1'b0 : cur[i-1];
        else            nb = (i == R - 1) ? 1'b0 : cur[i+1];
        nxt[i] = ~(v[(j-1)*R + i] & nb) ^ cur[i];
      end
      if (j % SP == 0) begin
        if (mode % 2 == 1)
          for (int n = 0; n < R / 4; n++) nxt[4*n +: 4] = SBOX_REF[nxt[4*n +: 4]];
        if (mode >= 2) begin
          tmp = nxt;
          for (int i = 0; i < R - 1; i++) nxt[(i * (R / 4)) % (R - 1)] = tmp[i];
          nxt[R-1] = tmp[R-1];
        end
      end
      cur = nxt;
    end
    return cur;
  endfunction

  task automatic checkVec(input string tag, input logic [R-1:0] act, input logic [R-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, captured at next posedge, sampled at the following negedge
  task automatic applyVec(input logic [R-1:0] c, input logic [CW-1:0] v);
    @(negedge clk);
    challenge = c;
    conn      = v;
    inValid   = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [R-1:0] c, e, held;
    logic [CW-1:0] v;
    longint hamSum;
    int trials;
    logic [31:0] s;

    // R7: reset state
    repeat (3) @(negedge clk);
    checkVec("R7 response in reset", resp3, '0);
    checkVec("R7 outValid in reset", {{(R-1){1'b0}}, ov3}, '0);
    rst_n = 1'b1;

    // table walk: R1, R2, R5 in all four modes
    for (int k = 0; k < 10; k++) begin
      c = expandBits(VEC_TABLE[k][63:32])[R-1:0];
      v = expandBits(VEC_TABLE[k][31:0]);
      applyVec(c, v);
      checkVec($sformatf("R6 outValid vec%0d", k), {{(R-1){1'b0}}, ov3}, {{(R-1){1'b0}}, 1'b1});
      checkVec($sformatf("R5 mode0 vec%0d", k), resp0, refModel(c, v, 0));
      checkVec($sformatf("R5 mode1 vec%0d", k), resp1, refModel(c, v, 1));
      checkVec($sformatf("R5 mode2 vec%0d", k), resp2, refModel(c, v, 2));
      checkVec($sformatf("R2 mode3 vec%0d", k), resp3, refModel(c, v, 3));
      inValid = 1'b0;
    end

    // R1: all-open grid in XOR-only mode with even column count returns the challenge
    c = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    applyVec(c, '0);
    checkVec("R1 open grid identity", resp0, c);
    inValid = 1'b0;

    // R6: no strobe -> response held, outValid low
    held = resp3;
    challenge = ~c;
    conn = expandBits(32'h5555_AAAA);
    @(negedge clk);
    @(negedge clk);
    checkVec("R6 response held", resp3, held);
    checkVec("R6 outValid low", {{(R-1){1'b0}}, ov3}, '0);

    // R3: every substitution entry
    for (int x = 0; x < 16; x++) begin
      sbChal = ~x[3:0];
      #1;
      checkVec($sformatf("R3 sbox %0h", x), {{(R-4){1'b0}}, sbResp}, {{(R-4){1'b0}}, SBOX_REF[x]});
    end

    // R4: every permutation destination
    for (int i = 0; i < R; i++) begin
      pmChal = ~(128'b1 << i);
      #1;
      e = (i == R - 1) ? (128'b1 << (R - 1)) : (128'b1 << ((i * (R / 4)) % (R - 1)));
      checkVec($sformatf("R4 perm bit %0d", i), pmResp, e);
    end

    // R8: avalanche in full mode
    hamSum = 0;
    trials = 100;
    s = 32'h9E37_79B9;
    for (int t = 0; t < trials; t++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      c = expandBits(s)[R-1:0];
      v = expandBits(s ^ 32'h5A5A_1234);
      applyVec(c, v);
      held = resp3;
      inValid = 1'b0;
      applyVec(c ^ (128'b1 << (t % R)), v);
      hamSum += $countones(held ^ resp3);
      inValid = 1'b0;
    end
    nChecks++;
    if (hamSum * 100 < longint'(35 * R * trials) || hamSum * 100 > longint'(65 * R * trials)) begin
      nFails++;
      $display("FAIL R8 avalanche: actual %0d flipped bits, expected %0d..%0d",
               hamSum, 35 * R * trials / 100, 65 * R * trials / 100);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule